// File: doc/BRIEF.md
# Phase-Staggered Four-Channel Heater Sequencer

This block turns one measured heating pulse (an on time and a period, delivered together with a strobe) into four staggered gate-enable waveforms, one for each heater switch. Each channel gets the full on time, but the channels start one after another from the beginning of the input period, so the supply never sees all heaters switch together. The on time may already be scaled for battery voltage upstream; the block uses whatever value it is given.

A new sequence begins with the first strobe seen while the block is enabled. The spacing between consecutive channel starts follows a five-step schedule, advancing one step per strobe. The first period uses a short fixed spacing, so every channel fires once inside it. The spacing then moves linearly toward the on time plus a guard gap. From the fifth period on, each channel starts only after the previous one has been off for the guard gap. Each channel also raises a blanking flag after every switching edge, so a fault detector downstream can ignore switching transients. An overcurrent trip shuts its channel off until reset, and a global-off input shuts all channels off while it is held.

Top module: `hs_sequencer_top`

## Requirements
- R1: While reset is asserted and after its release, every gate enable and every blanking flag is low until a sequence starts.
- R2: Let the strobe be sampled at edge E while `enable_i` is high. Channel k (k = 0..3) is high from edge E+1+k*S until edge E+1+k*S+T, where S is the stagger spacing and T is the on time latched at E. It is high only while the sequence is active.
- R3: In the first period of a sequence the spacing S equals START_DLY cycles (default 20). With a short on time, all four channels therefore fire within that first period.
- R4: In periods 2, 3 and 4 the spacing is START_DLY + trunc((T+GAP_CYC-START_DLY)*(p-1)/4), where p is the period number and trunc rounds toward zero. The schedule advances exactly once per strobe.
- R5: From period 5 onward the spacing is T+GAP_CYC (default gap 4 cycles). Once a full period has been spent at this step, at most one channel is high in any cycle.
- R6: Whenever a channel output changes, its blanking flag goes high in the same cycle and stays high for exactly BLANK_CYC cycles (default 6). A further change restarts the count.
- R7: A high `oc_trip_i[k]` forces channel k low at the next edge. The channel then stays low until reset, whatever happens later on the strobe or enable inputs.
- R8: While `global_off_i` is high, all channels are low from the next edge. When it is released, each channel follows its schedule window again.
- R9: With `enable_i` low, all channels are low from the next edge and the schedule returns to idle. The next strobe with enable high starts again at period 1 (spacing START_DLY).
- R10: Each strobe latches the on time and period inputs and restarts the in-period cycle count from zero. Without a strobe the count saturates at its maximum value and does not wrap.
- R11: No channel window extends past the latched period. A channel is high only while the in-period count is below the period value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Sequencer enable; low returns the schedule to idle |
| meas_strobe_i | input | 1 | One-cycle pulse at the start of each input period |
| meas_on_i | input | CNT_W | Measured (optionally pre-scaled) on time in cycles |
| meas_period_i | input | CNT_W | Measured input period in cycles |
| oc_trip_i | input | NCH | Per-channel overcurrent trip; latched until reset |
| global_off_i | input | 1 | Forces all channels off while high |
| gate_en_o | output | NCH | Per-channel gate enable |
| fault_blank_o | output | NCH | Per-channel fault-blanking flag after each switching edge |

## Verification
The non-overlap property assumes legal pacing from the source of the period measurements. Strobes must arrive no sooner than the latched period value. At the settled step, the last window start plus the on time must either fit inside the period or be cut off by the period clip. The stimulus only uses on times and periods that satisfy this: periods of 200 and 150 cycles against on times of 10 and 40. The clipping case is deliberate, and there channel 3 is cut at the period boundary. The other properties (global off, enable, trip latch, blanking after edges) hold for any input sequence. The stimulus still exercises each of them while channels are in the middle of a window, so each one can fail.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    // Linear point on the stagger schedule: step 1 gives base, step >= steps
    // gives target, steps between are interpolated with truncation toward zero.
    function automatic logic [31:0] hs_ramp_point(
        input logic [31:0] base,
        input logic [31:0] target,
        input logic [31:0] step,
        input logic [31:0] steps
    );
        logic [31:0] span;
        logic [31:0] part;
        span = 32'd0;
        part = 32'd0;
        if (step <= 32'd1) begin
            return base;
        end
        if (step >= steps) begin
            return target;
        end
        if (target >= base) begin
            span = target - base;
            part = (span * (step - 32'd1)) / (steps - 32'd1);
            return base + part;
        end
        span = base - target;
        part = (span * (step - 32'd1)) / (steps - 32'd1);
        return base - part;
    endfunction

endpackage

// File: rtl/hs_offset_ramp.sv
module hs_offset_ramp
    import hs_seq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int OFF_W      = 17,
    parameter int STEP_W     = 3,
    parameter int START_DLY  = 20,
    parameter int GAP_CYC    = 4,
    parameter int RAMP_STEPS = 5
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [CNT_W-1:0]  on_len_i,
    output logic [OFF_W-1:0]  offset_o
);

    logic [31:0] target;
    logic [31:0] point;

    always_comb begin
        target   = 32'(on_len_i) + 32'(GAP_CYC);
        point    = hs_ramp_point(32'(START_DLY), target, 32'(step_i), 32'(RAMP_STEPS));
        offset_o = OFF_W'(point);
    end

endmodule

// File: rtl/hs_chan_slot.sv
module hs_chan_slot #(
    parameter int CNT_W     = 16,
    parameter int OFF_W     = 17,
    parameter int START_W   = 20,
    parameter int IDX       = 0,
    parameter int BLANK_CYC = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CNT_W-1:0] pcnt_i,
    input  logic [CNT_W-1:0] on_len_i,
    input  logic [CNT_W-1:0] per_len_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic             gate_o,
    output logic             blank_o
);

    localparam int BL_W = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic            gate;
        logic [BL_W-1:0] blank;
    } slot_st_t;

    slot_st_t st_d, st_q;

    logic [START_W-1:0] t_start;
    logic [START_W-1:0] t_stop;
    logic [START_W-1:0] t_now;
    logic [START_W-1:0] t_per;
    logic               in_win;

    always_comb begin
        t_start = START_W'(IDX) * START_W'(offset_i);
        t_stop  = t_start + START_W'(on_len_i);
        t_now   = START_W'(pcnt_i);
        t_per   = START_W'(per_len_i);
        in_win  = run_i && (t_now >= t_start) && (t_now < t_stop) && (t_now < t_per);

        st_d      = st_q;
        st_d.gate = in_win;
        if (in_win != st_q.gate) begin
            st_d.blank = BL_W'(BLANK_CYC);
        end else if (st_q.blank != '0) begin
            st_d.blank = st_q.blank - BL_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o  = st_q.gate;
    assign blank_o = (st_q.blank != '0);

endmodule

// File: rtl/hs_sequencer_top.sv
module hs_sequencer_top
    import hs_seq_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CNT_W      = 16,
    parameter int START_DLY  = 20,
    parameter int GAP_CYC    = 4,
    parameter int BLANK_CYC  = 6,
    parameter int RAMP_STEPS = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             meas_strobe_i,
    input  logic [CNT_W-1:0] meas_on_i,
    input  logic [CNT_W-1:0] meas_period_i,
    input  logic [NCH-1:0]   oc_trip_i,
    input  logic             global_off_i,
    output logic [NCH-1:0]   gate_en_o,
    output logic [NCH-1:0]   fault_blank_o
);

    localparam int STEP_W  = $clog2(RAMP_STEPS + 1);
    localparam int OFF_W   = CNT_W + 1;
    localparam int START_W = OFF_W + $clog2(NCH) + 1;
    localparam logic [CNT_W-1:0]  PCNT_MAX  = '1;
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(RAMP_STEPS);

    typedef struct packed {
        logic              active;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  pcnt;
        logic [CNT_W-1:0]  on_len;
        logic [CNT_W-1:0]  per_len;
        logic [OFF_W-1:0]  offset;
        logic [NCH-1:0]    oc_lat;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic [STEP_W-1:0] step_state;
    logic [STEP_W-1:0] step_nx;
    logic [OFF_W-1:0]  off_nx;
    logic [NCH-1:0]    oc_state;
    logic [NCH-1:0]    run;

    assign step_state = s_q.step;
    assign oc_state   = s_q.oc_lat;
    assign step_nx    = (step_state < STEP_LAST) ? step_state + STEP_W'(1) : step_state;

    hs_offset_ramp #(
        .CNT_W      (CNT_W),
        .OFF_W      (OFF_W),
        .STEP_W     (STEP_W),
        .START_DLY  (START_DLY),
        .GAP_CYC    (GAP_CYC),
        .RAMP_STEPS (RAMP_STEPS)
    ) u_ramp (
        .step_i   (step_nx),
        .on_len_i (meas_on_i),
        .offset_o (off_nx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.oc_lat = s_q.oc_lat | oc_trip_i;
        if (!enable_i) begin
            s_d.active = 1'b0;
            s_d.step   = '0;
        end else if (meas_strobe_i) begin
            s_d.active  = 1'b1;
            s_d.step    = step_nx;
            s_d.pcnt    = '0;
            s_d.on_len  = meas_on_i;
            s_d.per_len = meas_period_i;
            s_d.offset  = off_nx;
        end else if (s_q.pcnt != PCNT_MAX) begin
            s_d.pcnt = s_q.pcnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run = {NCH{s_q.active & enable_i & ~global_off_i}} & ~(oc_state | oc_trip_i);

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            hs_chan_slot #(
                .CNT_W     (CNT_W),
                .OFF_W     (OFF_W),
                .START_W   (START_W),
                .IDX       (k),
                .BLANK_CYC (BLANK_CYC)
            ) u_slot (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .run_i     (run[k]),
                .pcnt_i    (s_q.pcnt),
                .on_len_i  (s_q.on_len),
                .per_len_i (s_q.per_len),
                .offset_i  (s_q.offset),
                .gate_o    (gate_en_o[k]),
                .blank_o   (fault_blank_o[k])
            );
        end
    endgenerate

endmodule

// File: rtl/hs_sequencer_chk.sv
module hs_sequencer_chk #(
    parameter int NCH        = 4,
    parameter int STEP_W     = 3,
    parameter int RAMP_STEPS = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              enable_i,
    input logic              global_off_i,
    input logic [NCH-1:0]    gate_en_o,
    input logic [NCH-1:0]    fault_blank_o,
    input logic [NCH-1:0]    oc_state,
    input logic [STEP_W-1:0] step_state
);

    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(RAMP_STEPS);

    AST_GLOBAL_OFF_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        global_off_i |=> (gate_en_o == '0)); // R8

    AST_DISABLE_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (gate_en_o == '0)); // R9

    AST_TRIPPED_CHANNEL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((oc_state & gate_en_o) == '0)); // R7

    AST_EDGE_RAISES_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((gate_en_o ^ $past(gate_en_o)) & ~fault_blank_o) == '0); // R6

    AST_SETTLED_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((step_state == STEP_LAST) && ($past(step_state) == STEP_LAST)) |-> $onehot0(gate_en_o)); // R5

endmodule

bind hs_sequencer_top hs_sequencer_chk #(
    .NCH        (NCH),
    .STEP_W     (STEP_W),
    .RAMP_STEPS (RAMP_STEPS)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .global_off_i  (global_off_i),
    .gate_en_o     (gate_en_o),
    .fault_blank_o (fault_blank_o),
    .oc_state      (oc_state),
    .step_state    (step_state)
);

// File: tb/hs_sequencer_top_tb_top.sv
module hs_sequencer_top_tb_top;

    localparam int NCH   = 4;
    localparam int CNT_W = 16;
    localparam int DLY   = 20;
    localparam int GAP   = 4;
    localparam int BLK   = 6;
    localparam int STEPS = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             strobe = 1'b0;
    logic             goff = 1'b0;
    logic [CNT_W-1:0] on_in = '0;
    logic [CNT_W-1:0] per_in = '0;
    logic [NCH-1:0]   oc_trip = '0;
    logic [NCH-1:0]   gate;
    logic [NCH-1:0]   blank;

    always #2 clk = ~clk;

    hs_sequencer_top dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .enable_i      (en),
        .meas_strobe_i (strobe),
        .meas_on_i     (on_in),
        .meas_period_i (per_in),
        .oc_trip_i     (oc_trip),
        .global_off_i  (goff),
        .gate_en_o     (gate),
        .fault_blank_o (blank)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int             md_act = 0, md_step = 0, md_pc = 0, md_on = 0, md_per = 0, md_off = 0;
    logic [NCH-1:0] md_oc = '0;
    logic [NCH-1:0] ex_gate = '0;
    logic [NCH-1:0] nxt = '0;
    int             ex_bl[NCH];

    function automatic int ref_off(input int step, input int on_t);
        if (step <= 1) return DLY;
        if (step >= STEPS) return on_t + GAP;
        return DLY + ((on_t + GAP - DLY) * (step - 1)) / (STEPS - 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            md_act = 0; md_step = 0; md_pc = 0; md_on = 0; md_per = 0; md_off = 0;
            md_oc = '0; ex_gate = '0;
            for (int k = 0; k < NCH; k++) ex_bl[k] = 0;
        end else begin
            for (int k = 0; k < NCH; k++) begin
                nxt[k] = (md_act != 0) && en && !goff && !md_oc[k] && !oc_trip[k]
                         && (md_pc >= k * md_off) && (md_pc < k * md_off + md_on)
                         && (md_pc < md_per);
                if (nxt[k] != ex_gate[k]) ex_bl[k] = BLK;
                else if (ex_bl[k] > 0) ex_bl[k] = ex_bl[k] - 1;
            end
            ex_gate = nxt;
            md_oc = md_oc | oc_trip;
            if (!en) begin
                md_act = 0;
                md_step = 0;
            end else if (strobe) begin
                if (md_step < STEPS) md_step = md_step + 1;
                md_off = ref_off(md_step, int'(on_in));
                md_on  = int'(on_in);
                md_per = int'(per_in);
                md_pc  = 0;
                md_act = 1;
            end else if (md_pc < 65535) begin
                md_pc = md_pc + 1;
            end
        end
    end

    // ---------------- monitor, sampled on the falling edge ----------------
    logic [NCH-1:0] prev_gate = '0;
    logic [NCH-1:0] ex_blank;
    int             rt0 = -1;
    bit             chk_rise = 1'b1;
    int             hi_cnt[NCH];
    bit             done = 1'b0;

    initial for (int k = 0; k < NCH; k++) begin
        hi_cnt[k] = 0;
        ex_bl[k] = 0;
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            for (int k = 0; k < NCH; k++) ex_blank[k] = (ex_bl[k] != 0);
            chk((gate == ex_gate) && (blank == ex_blank), "R2 R6 R10 R11 model compare",
                int'({gate, blank}), int'({ex_gate, ex_blank}));
            if (gate[0] && !prev_gate[0]) begin
                rt0 = cyc;
                chk(blank[0] == 1'b1, "R6 blank at rising edge", int'(blank[0]), 1);
            end
            if (chk_rise && gate[1] && !prev_gate[1] && rt0 >= 0) begin
                if (md_step == 1)
                    chk(cyc - rt0 == md_off, "R3 first-period spacing", cyc - rt0, md_off);
                else if (md_step < STEPS)
                    chk(cyc - rt0 == md_off, "R4 ramp spacing", cyc - rt0, md_off);
                else
                    chk(cyc - rt0 == md_off, "R5 settled spacing", cyc - rt0, md_off);
            end
            for (int k = 0; k < NCH; k++) if (gate[k]) hi_cnt[k]++;
        end
        prev_gate = gate;
        if (cyc > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_period(input int on_t, input int per, input int spacing);
        strobe = 1'b1;
        on_in  = CNT_W'(on_t);
        per_in = CNT_W'(per);
        tick(1);
        strobe = 1'b0;
        tick(spacing - 1);
    endtask

    initial begin
        int base[NCH];
        tick(3);
        chk(gate == '0, "R1 gates low in reset", int'(gate), 0);
        chk(blank == '0, "R1 blanking low in reset", int'(blank), 0);
        rst_n = 1'b1;
        tick(3);
        chk(gate == '0 && blank == '0, "R1 idle after reset", int'({gate, blank}), 0);

        // descending ramp: short on time
        en = 1'b1;
        repeat (6) do_period(10, 200, 200);

        // disable, then restart from period 1 with an ascending ramp
        en = 1'b0;
        tick(3);
        chk(gate == '0, "R9 all off when disabled", int'(gate), 0);
        tick(5);
        en = 1'b1;
        repeat (6) do_period(40, 200, 200);

        // period clip on channel 3 (start 132, clipped at 150)
        repeat (2) do_period(40, 150, 150);
        for (int k = 0; k < NCH; k++) base[k] = hi_cnt[k];
        do_period(40, 150, 150);
        chk(hi_cnt[3] - base[3] == 18, "R11 window clipped at period", hi_cnt[3] - base[3], 18);
        chk(hi_cnt[0] - base[0] == 40, "R10 on time latched per strobe", hi_cnt[0] - base[0], 40);

        // latched overcurrent on channel 2
        oc_trip = 4'b0100;
        tick(1);
        oc_trip = '0;
        do_period(40, 150, 150);
        for (int k = 0; k < NCH; k++) base[k] = hi_cnt[k];
        repeat (2) do_period(40, 150, 150);
        chk(hi_cnt[2] - base[2] == 0, "R7 tripped channel stays off", hi_cnt[2] - base[2], 0);
        chk(hi_cnt[1] - base[1] == 80, "R7 other channels unaffected", hi_cnt[1] - base[1], 80);

        // global off in the middle of channel 1's window
        chk_rise = 1'b0;
        strobe = 1'b1;
        tick(1);
        strobe = 1'b0;
        tick(50);
        goff = 1'b1;
        tick(1);
        for (int i = 0; i < 20; i++) begin
            tick(1);
            chk(gate == '0, "R8 global off holds all low", int'(gate), 0);
        end
        goff = 1'b0;
        tick(78);
        chk_rise = 1'b1;
        do_period(40, 150, 150);

        // second restart: spacing back to the fixed delay
        en = 1'b0;
        tick(4);
        chk(gate == '0, "R9 off again after disable", int'(gate), 0);
        en = 1'b1;
        do_period(10, 200, 200);
        do_period(10, 200, 200);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule